// File: doc/BRIEF.md
# Linear and Circular Pointer Step Unit

This block is the address arithmetic of a load/store datapath. Each cycle it receives the current value of an address register, the index of that register, an offset, an access size and a step operation. From these it produces two results in the same cycle. The first is the effective address used for the memory access. The second is the updated pointer value that the register file writes back.

The offset is either a small unsigned constant or a full-width register value. It is scaled by the access size. It is then added to or subtracted from the pointer, before the access (pre-step) or after it (post-step).

A mode register, loaded through a synchronous write port, picks linear or circular arithmetic for each of a fixed group of address registers: numbers 4 to 7 on each of the two register sides. In circular mode the buffer is a power-of-two block. Only the low bits inside the block take part in the arithmetic, so the pointer wraps while the bits above the block stay untouched. Every other register index always steps linearly.

Top module: `ptr_arith_unit`

## Requirements
- R1: After reset the mode register is all zero, so every register index steps linearly.
- R2: `cfgWrData` is loaded into the mode register on a rising edge where `cfgWrEn` is 1, and it governs results from that edge on. While `cfgWrEn` is 0, `cfgWrData` has no effect.
- R3: The offset is `offsetReg` when `offSrcReg` is 1. Otherwise it is `constOff`, zero-extended. It is multiplied by 1, 2, 4 or 4 for `accSize` codes 00, 01, 10 and 11.
- R4: Linear stepping adds or subtracts the scaled offset modulo 2^32.
- R5: Circular stepping with size field value F changes only address bits F down to 0, as a sum modulo 2^(F+1). Bits 31 down to F+1 of the updated value equal those of `baseAddr`.
- R6: `regIdx` bit 5 is the side and bits 4:0 are the register number. For register number n in 4..7 on side s, the mode code is in `modeReg` bits [2k+1:2k], with k = 4*s + n - 4. The codes are: 00 linear; 01 circular with size field 0 (bits 20:16); 10 circular with size field 1 (bits 25:21); 11 linear.
- R7: Register numbers outside 4..7 on either side always step linearly, whatever the mode register holds.
- R8: `opSel` codes are 00 pre-increment, 01 pre-decrement, 10 post-increment and 11 post-decrement. Pre-step operations output the updated value as `effAddr`. Post-step operations output `baseAddr` as `effAddr`. `newBase` is the updated value in every case.
- R9: `effAddr` and `newBase` are combinational in the current inputs and mode register, with no cycle of latency.
- R10: A size field of 31 makes the circular block span all 32 bits, so the result equals linear stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode register |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Mode register write enable |
| cfgWrData | input | 26 | Mode register write value (per-register codes and two size fields) |
| regIdx | input | 6 | Side (bit 5) and number (bits 4:0) of the address register |
| baseAddr | input | 32 | Current value of the address register |
| offsetReg | input | 32 | Register-sourced offset |
| constOff | input | 5 | Unsigned constant offset |
| offSrcReg | input | 1 | 1 selects offsetReg, 0 selects constOff |
| accSize | input | 2 | Access size code used for offset scaling |
| opSel | input | 2 | Step operation code |
| effAddr | output | 32 | Effective memory address |
| newBase | output | 32 | Updated address register value |

## Verification
Both arithmetic results are due in the same cycle as their inputs. The bench therefore drives each vector on the falling clock edge and compares against its model one nanosecond later, before the next rising edge. A mode register write only takes effect at the rising edge that samples it. For that reason the bench updates its own model copy at that edge, and it checks the new behaviour only from the following falling edge. A write attempted with the enable low is checked in the same way on the cycle after that edge, and it must leave the old behaviour intact.

// File: rtl/ptr_arith_pkg.sv
package ptr_arith_pkg;

  localparam int ADDR_W     = 32;
  localparam int SIZE_FLD_W = 5;
  localparam int CONST_W    = 5;

  typedef enum logic [1:0] {
    OP_PRE_INC  = 2'b00,
    OP_PRE_DEC  = 2'b01,
    OP_POST_INC = 2'b10,
    OP_POST_DEC = 2'b11
  } stepOp_e;

  typedef enum logic [1:0] {
    MODE_LINEAR = 2'b00,
    MODE_CIRC0  = 2'b01,
    MODE_CIRC1  = 2'b10,
    MODE_RSVD   = 2'b11
  } ptrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                  circOn;
    logic [SIZE_FLD_W-1:0] sizeFld;
    logic                  subtract;
    logic                  preMode;
    logic [1:0]            scaleSh;
  } arithCtl_t;

endpackage

// File: rtl/ptr_mode_ctrl.sv
module ptr_mode_ctrl
  import ptr_arith_pkg::*;
#(
  parameter int IDX_W         = 5,
  parameter int SIDE_CNT      = 2,
  parameter int CIRC_FIRST    = 4,
  parameter int CIRC_PER_SIDE = 4,
  localparam int SIDE_W = (SIDE_CNT > 1) ? $clog2(SIDE_CNT) : 1,
  localparam int ELIG   = SIDE_CNT * CIRC_PER_SIDE,
  localparam int MODE_W = 2 * ELIG,
  localparam int CFG_W  = MODE_W + 2 * SIZE_FLD_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWrEn,
  input  logic [CFG_W-1:0]        cfgWrData,
  input  logic [SIDE_W+IDX_W-1:0] regIdx,
  input  logic [1:0]              accSize,
  input  logic [1:0]              opSel,
  output arithCtl_t               ctlOut
);

  logic [CFG_W-1:0]      modeReg;
  logic [SIZE_FLD_W-1:0] sizeFld0;
  logic [SIZE_FLD_W-1:0] sizeFld1;
  logic [1:0]            slotCode [ELIG];
  logic [SIDE_W-1:0]     sideSel;
  logic [IDX_W-1:0]      regNum;
  logic                  eligible;
  ptrMode_e              modeSel;

  always_ff @(posedge clk) begin
    if (!rstN)        modeReg <= '0;
    else if (cfgWrEn) modeReg <= cfgWrData;
  end

  assign sizeFld0 = modeReg[MODE_W +: SIZE_FLD_W];
  assign sizeFld1 = modeReg[MODE_W + SIZE_FLD_W +: SIZE_FLD_W];

  for (genvar s = 0; s < ELIG; s++) begin : g_slot
    assign slotCode[s] = modeReg[2*s +: 2];
  end

  assign sideSel = regIdx[IDX_W +: SIDE_W];
  assign regNum  = regIdx[IDX_W-1:0];
  assign eligible = (int'(regNum) >= CIRC_FIRST) &&
                    (int'(regNum) <  CIRC_FIRST + CIRC_PER_SIDE) &&
                    (int'(sideSel) < SIDE_CNT);

  always_comb begin
    int slot;
    slot    = int'(sideSel) * CIRC_PER_SIDE + int'(regNum) - CIRC_FIRST;
    modeSel = MODE_LINEAR;
    if (eligible && slot >= 0 && slot < ELIG) modeSel = ptrMode_e'(slotCode[slot]);
  end

  always_comb begin
    ctlOut.circOn   = (modeSel == MODE_CIRC0) || (modeSel == MODE_CIRC1);
    ctlOut.sizeFld  = (modeSel == MODE_CIRC1) ? sizeFld1 : sizeFld0;
    ctlOut.subtract = (opSel == OP_PRE_DEC) || (opSel == OP_POST_DEC);
    ctlOut.preMode  = (opSel == OP_PRE_INC) || (opSel == OP_PRE_DEC);
    ctlOut.scaleSh  = (accSize == 2'b11) ? 2'b10 : accSize;
  end

  // R2: a write lands on the next edge
  a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (modeReg == $past(cfgWrData)));
  // R2: no enable, no change
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWrEn && !$rose(rstN)) |=> $stable(modeReg));
  // R7: registers outside the window never go circular
  a_r7_outside_linear: assert property (@(posedge clk) disable iff (!rstN)
    ((int'(regIdx[IDX_W-1:0]) < CIRC_FIRST) ||
     (int'(regIdx[IDX_W-1:0]) >= CIRC_FIRST + CIRC_PER_SIDE)) |-> !ctlOut.circOn);

endmodule

// File: rtl/ptr_step_dp.sv
module ptr_step_dp
  import ptr_arith_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  arithCtl_t          ctlIn,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [ADDR_W-1:0]  offsetReg,
  input  logic [CONST_W-1:0] constOff,
  input  logic               offSrcReg,
  output logic [ADDR_W-1:0]  effAddr,
  output logic [ADDR_W-1:0]  newBase
);

  logic [ADDR_W-1:0] offRaw;
  logic [ADDR_W-1:0] offScaled;
  logic [ADDR_W-1:0] stepped;
  logic [ADDR_W-1:0] lowMask;

  assign offRaw    = offSrcReg ? offsetReg : {{(ADDR_W-CONST_W){1'b0}}, constOff};
  assign offScaled = offRaw << ctlIn.scaleSh;
  assign stepped   = ctlIn.subtract ? (baseAddr - offScaled) : (baseAddr + offScaled);

  // one mask bit per address bit: inside the block when bit index <= size field
  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    assign lowMask[b] = (b <= int'(ctlIn.sizeFld));
  end

  assign newBase = ctlIn.circOn ? ((baseAddr & ~lowMask) | (stepped & lowMask)) : stepped;
  assign effAddr = ctlIn.preMode ? newBase : baseAddr;

  // R5: bits above the block survive a circular step
  a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    ctlIn.circOn |-> (((newBase ^ baseAddr) & ~lowMask) == '0));
  // R8: post-step addresses with the old pointer
  a_r8_post_uses_base: assert property (@(posedge clk) disable iff (!rstN)
    !ctlIn.preMode |-> (effAddr == baseAddr));
  // R8: pre-step addresses with the updated pointer
  a_r8_pre_uses_new: assert property (@(posedge clk) disable iff (!rstN)
    ctlIn.preMode |-> (effAddr == newBase));

endmodule

// File: rtl/ptr_arith_unit.sv
module ptr_arith_unit
  import ptr_arith_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [25:0]        cfgWrData,
  input  logic [5:0]         regIdx,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [ADDR_W-1:0]  offsetReg,
  input  logic [CONST_W-1:0] constOff,
  input  logic               offSrcReg,
  input  logic [1:0]         accSize,
  input  logic [1:0]         opSel,
  output logic [ADDR_W-1:0]  effAddr,
  output logic [ADDR_W-1:0]  newBase
);

  arithCtl_t ctlBus;

  ptr_mode_ctrl #(
    .IDX_W(5), .SIDE_CNT(2), .CIRC_FIRST(4), .CIRC_PER_SIDE(4)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .regIdx(regIdx), .accSize(accSize), .opSel(opSel), .ctlOut(ctlBus)
  );

  ptr_step_dp u_dp (
    .clk(clk), .rstN(rstN), .ctlIn(ctlBus), .baseAddr(baseAddr),
    .offsetReg(offsetReg), .constOff(constOff), .offSrcReg(offSrcReg),
    .effAddr(effAddr), .newBase(newBase)
  );

endmodule

// File: tb/ptr_arith_unit_tb.sv
module ptr_arith_unit_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [25:0] cfgWrData;
  logic [5:0]  regIdx;
  logic [31:0] baseAddr, offsetReg;
  logic [4:0]  constOff;
  logic        offSrcReg;
  logic [1:0]  accSize, opSel;
  logic [31:0] effAddr, newBase;

  int testsRun = 0;
  int testsFailed = 0;
  logic [25:0] modelMode;

  always #4 clk = ~clk;

  ptr_arith_unit u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .regIdx(regIdx), .baseAddr(baseAddr), .offsetReg(offsetReg),
    .constOff(constOff), .offSrcReg(offSrcReg), .accSize(accSize),
    .opSel(opSel), .effAddr(effAddr), .newBase(newBase)
  );

  // behavioural reference: modulo arithmetic on a block of size blk
  function automatic void refStep(input logic [25:0] m, input logic [5:0] idx,
      input logic [31:0] base, input logic [31:0] offR, input logic [4:0] c,
      input logic src, input logic [1:0] sz, input logic [1:0] op,
      output logic [31:0] eff, output logic [31:0] nb);
    longint off, mul, delta, blk, lowv, newLow, full;
    int num, side, slot, code;
    off   = src ? longint'(offR) : longint'(c);
    mul   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    delta = op[0] ? -(off * mul) : (off * mul);
    num   = int'(idx[4:0]);
    side  = int'(idx[5]);
    blk   = longint'(1) << 32;
    if (num >= 4 && num <= 7) begin
      slot = side * 4 + num - 4;
      code = int'((m >> (2 * slot)) & 26'd3);
      if (code == 1) blk = longint'(1) << (int'(m[20:16]) + 1);
      if (code == 2) blk = longint'(1) << (int'(m[25:21]) + 1);
    end
    lowv   = longint'(base) % blk;
    newLow = (((lowv + delta) % blk) + blk) % blk;
    full   = longint'(base) - lowv + newLow;
    nb     = full[31:0];
    eff    = op[1] ? base : nb;
  endfunction

  task automatic applyCheck(input string req, input logic [5:0] idx,
      input logic [31:0] base, input logic [31:0] offR, input logic [4:0] c,
      input logic src, input logic [1:0] sz, input logic [1:0] op);
    logic [31:0] expEff, expNb;
    @(negedge clk);
    regIdx = idx; baseAddr = base; offsetReg = offR; constOff = c;
    offSrcReg = src; accSize = sz; opSel = op;
    #1;
    refStep(modelMode, idx, base, offR, c, src, sz, op, expEff, expNb);
    testsRun++;
    if (effAddr !== expEff || newBase !== expNb) begin
      testsFailed++;
      $display("FAIL %s idx=%0d base=%h: eff=%h nb=%h expected eff=%h nb=%h",
               req, idx, base, effAddr, newBase, expEff, expNb);
    end
  endtask

  task automatic writeMode(input logic [25:0] d, input logic en);
    @(negedge clk);
    cfgWrEn = en; cfgWrData = d;
    @(posedge clk);
    if (en) modelMode = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    testsFailed++;
    $display("FAIL R9 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [25:0] cfgA;
    rstN = 1'b0; cfgWrEn = 1'b0; cfgWrData = '0; regIdx = '0; baseAddr = '0;
    offsetReg = '0; constOff = '0; offSrcReg = 1'b0; accSize = '0; opSel = '0;
    modelMode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset leaves register 4 linear (0xFF+1 carries out of low bits)
    applyCheck("R1", 6'd4, 32'h0000_00FF, 32'h0, 5'd1, 1'b0, 2'b00, 2'b00);

    // A4=01, A5=10, A6=11, B7=01, size field0=3 (16 B), field1=7 (256 B)
    cfgA = 26'h1 | (26'h2 << 2) | (26'h3 << 4) | (26'h1 << 14) | (26'd3 << 16) | (26'd7 << 21);
    writeMode(cfgA, 1'b1);

    // R5/R8: A4 post-inc word const 2 -> 0x1000_0004, eff 0x1000_000C
    applyCheck("R5", 6'd4, 32'h1000_000C, 32'h0, 5'd2, 1'b0, 2'b10, 2'b10);
    // R3/R8: A4 pre-dec register offset 5 bytes -> 0x1000_0007
    applyCheck("R3", 6'd4, 32'h1000_000C, 32'd5, 5'd0, 1'b1, 2'b00, 2'b01);
    // R6: A5 uses field1: 0x2000_00F0 + 18 -> 0x2000_0002
    applyCheck("R6", 6'd5, 32'h2000_00F0, 32'h0, 5'd9, 1'b0, 2'b01, 2'b10);
    // R6: A6 reserved code is linear -> 0x2000_0102
    applyCheck("R6", 6'd6, 32'h2000_00F0, 32'h0, 5'd9, 1'b0, 2'b01, 2'b00);
    // R6: B7 circular with field0, pre-dec below zero wraps to top of block
    applyCheck("R6", 6'd39, 32'h3000_0002, 32'h0, 5'd1, 1'b0, 2'b10, 2'b01);
    // R6: B4 has code 00 -> linear
    applyCheck("R6", 6'd36, 32'h3000_000E, 32'h0, 5'd1, 1'b0, 2'b10, 2'b00);
    // R7: A3 and A12 linear
    applyCheck("R7", 6'd3, 32'h1000_000C, 32'h0, 5'd2, 1'b0, 2'b10, 2'b10);
    applyCheck("R7", 6'd12, 32'h1000_000C, 32'h0, 5'd2, 1'b0, 2'b10, 2'b11);
    // R3: size code 11 scales by 4
    applyCheck("R3", 6'd8, 32'h0000_0100, 32'h0, 5'd3, 1'b0, 2'b11, 2'b00);
    // R4: linear wrap modulo 2^32
    applyCheck("R4", 6'd0, 32'hFFFF_FFF8, 32'h20, 5'd0, 1'b1, 2'b00, 2'b00);
    applyCheck("R4", 6'd1, 32'h0000_0004, 32'h10, 5'd0, 1'b1, 2'b00, 2'b11);

    // R2: disabled write has no effect
    writeMode(26'h0, 1'b0);
    applyCheck("R2", 6'd4, 32'h1000_000C, 32'h0, 5'd2, 1'b0, 2'b10, 2'b10);

    // R10: field0 = 31 on A4 behaves as full 32-bit wrap
    writeMode(26'h1 | (26'd31 << 16), 1'b1);
    applyCheck("R10", 6'd4, 32'hFFFF_FFF0, 32'h20, 5'd0, 1'b1, 2'b00, 2'b00);
    // R2: new mode governs from the cycle after the edge (A5 now linear)
    applyCheck("R2", 6'd5, 32'h2000_00F0, 32'h0, 5'd9, 1'b0, 2'b01, 2'b10);

    // R9/R5: random vectors compared each clock, mode rewritten now and then
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0) writeMode(26'($urandom), 1'b1);
      applyCheck("R9", 6'($urandom), $urandom, $urandom, 5'($urandom),
                 1'($urandom), 2'($urandom), 2'($urandom));
    end

    // R1: reset again clears the mode register
    @(negedge clk) rstN = 1'b0;
    @(posedge clk); modelMode = '0;
    @(negedge clk) rstN = 1'b1;
    applyCheck("R1", 6'd7, 32'h0000_00FF, 32'h0, 5'd1, 1'b0, 2'b00, 2'b00);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule